// File: doc/BRIEF.md
# Ten-Code Accumulator Datapath

This block is a small register-transfer engine built around three 8-bit registers: an accumulator, one general-purpose register and an output holding register. Every rising clock edge it carries out the single operation chosen by a 4-bit code on its input. An operation either moves a value between the external data bus and the registers, or changes the accumulator with an add, an OR, an AND or a bitwise inversion.

A surrounding controller supplies one code and one data byte per cycle. It reads the three register values straight from the outputs, one cycle after it issued the code. There is no sequencing logic inside the block. A code only decides which registers load on that edge, and from which source. A register that the current code does not name keeps its contents. Unused codes do nothing.

The active-low reset clears all three registers as soon as it is asserted. Its release is synchronized to the clock.

Top module: `tiny_acc_core`

## Requirements
- R1: Code 1 and code 6 each load the accumulator with the data bus value on that clock edge.
- R2: Code 2 copies the accumulator into the general register, and code 5 loads the general register from the data bus.
- R3: Code 3 writes the general register to the output register, and code 4 writes the accumulator to the output register.
- R4: Code 7 replaces the accumulator with the accumulator plus the general register, modulo 256; the carry-out is discarded.
- R5: Code 8 replaces the accumulator with accumulator OR general register, and code 9 with accumulator AND general register.
- R6: Code 10 replaces the accumulator with its bitwise complement.
- R7: The general register keeps its value under every code except 2 and 5.
- R8: The accumulator keeps its value under codes 2, 3, 4 and 5.
- R9: The output register keeps its value under every code except 3 and 4.
- R10: Code 0 and codes 11 through 15 leave all three registers unchanged, whatever the data bus carries.
- R11: While rst_n is low, all three registers read zero. After rst_n rises, the first two rising clock edges leave them at zero, and the third rising edge is the first one that carries out a code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously and released through a synchronizer |
| op_code | input | 4 | Operation code for this cycle, values 0 to 15 |
| data_in | input | 8 | External data bus |
| acc_q | output | 8 | Accumulator contents |
| gpr_q | output | 8 | General register contents |
| out_q | output | 8 | Output register contents |

## Verification
A directed run comes first. It loads 0xFF and 0x01 and adds them, which shows whether the add wraps and drops its carry. It then applies the inversion and the OR and AND operations to complementary operands such as 0xA5 and 0x5A, so that a swapped or inverted function gives a different result. Every unused code is then issued while the bus carries values that differ from all registers, so any stray load becomes visible. A long random stream of codes and bytes follows, with each register compared after every cycle. This catches a register that loads under a wrong code or fails to hold when it should. The reset sequence is checked edge by edge with a load code pending, which confirms the two-edge release latency.

// File: rtl/tac_pkg.sv
package tac_pkg;

  typedef enum logic [3:0] {
    OP_IDLE    = 4'd0,
    OP_LDA_BUS = 4'd1,
    OP_MOV_RA  = 4'd2,
    OP_OUT_R   = 4'd3,
    OP_OUT_A   = 4'd4,
    OP_LDR_BUS = 4'd5,
    OP_LDA_ALT = 4'd6,
    OP_ADD     = 4'd7,
    OP_IOR     = 4'd8,
    OP_IAND    = 4'd9,
    OP_INV     = 4'd10
  } op_e;

  typedef enum logic [2:0] {
    ASRC_BUS,
    ASRC_ADD,
    ASRC_IOR,
    ASRC_IAND,
    ASRC_INV
  } a_src_e;

  typedef struct packed {
    logic   a_en;
    a_src_e a_src;
    logic   r_en;
    logic   r_from_bus;
    logic   o_en;
    logic   o_from_acc;
  } ctl_t;

endpackage

// File: rtl/tac_rst_sync.sv
module tac_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/tac_decode.sv
module tac_decode
  import tac_pkg::*;
#(
  parameter int OP_W = 4
) (
  input  logic [OP_W-1:0] op_i,
  output ctl_t            ctl_o
);

  always_comb begin
    ctl_o            = '0;
    ctl_o.a_src      = ASRC_BUS;
    unique case (op_i)
      OP_LDA_BUS, OP_LDA_ALT: begin
        ctl_o.a_en  = 1'b1;
        ctl_o.a_src = ASRC_BUS;
      end
      OP_MOV_RA: begin
        ctl_o.r_en       = 1'b1;
        ctl_o.r_from_bus = 1'b0;
      end
      OP_LDR_BUS: begin
        ctl_o.r_en       = 1'b1;
        ctl_o.r_from_bus = 1'b1;
      end
      OP_OUT_R: begin
        ctl_o.o_en       = 1'b1;
        ctl_o.o_from_acc = 1'b0;
      end
      OP_OUT_A: begin
        ctl_o.o_en       = 1'b1;
        ctl_o.o_from_acc = 1'b1;
      end
      OP_ADD: begin
        ctl_o.a_en  = 1'b1;
        ctl_o.a_src = ASRC_ADD;
      end
      OP_IOR: begin
        ctl_o.a_en  = 1'b1;
        ctl_o.a_src = ASRC_IOR;
      end
      OP_IAND: begin
        ctl_o.a_en  = 1'b1;
        ctl_o.a_src = ASRC_IAND;
      end
      OP_INV: begin
        ctl_o.a_en  = 1'b1;
        ctl_o.a_src = ASRC_INV;
      end
      default: begin
        ctl_o = ctl_o;
      end
    endcase
  end

endmodule

// File: rtl/tac_alu.sv
module tac_alu
  import tac_pkg::*;
#(
  parameter int W = 8
) (
  input  a_src_e       sel_i,
  input  logic [W-1:0] acc_i,
  input  logic [W-1:0] gpr_i,
  input  logic [W-1:0] bus_i,
  output logic [W-1:0] y_o
);

  logic [W:0] sum_full;

  assign sum_full = {1'b0, acc_i} + {1'b0, gpr_i};

  always_comb begin
    unique case (sel_i)
      ASRC_ADD:  y_o = sum_full[W-1:0];
      ASRC_IOR:  y_o = acc_i | gpr_i;
      ASRC_IAND: y_o = acc_i & gpr_i;
      ASRC_INV:  y_o = ~acc_i;
      default:   y_o = bus_i;
    endcase
  end

endmodule

// File: rtl/tac_reg.sv
module tac_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_o <= '0;
    end else if (en_i) begin
      q_o <= d_i;
    end
  end

endmodule

// File: rtl/tiny_acc_core.sv
module tiny_acc_core
  import tac_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int OP_W      = 4,
  parameter int RST_STAGE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OP_W-1:0]   op_code,
  input  logic [DATA_W-1:0] data_in,
  output logic [DATA_W-1:0] acc_q,
  output logic [DATA_W-1:0] gpr_q,
  output logic [DATA_W-1:0] out_q
);

  localparam int NREG = 3;

  logic              rst_sync_n;
  ctl_t              ctl;
  logic [DATA_W-1:0] acc_next;
  logic [DATA_W-1:0] gpr_next;
  logic [DATA_W-1:0] out_next;

  logic [NREG-1:0]              reg_en;
  logic [NREG-1:0][DATA_W-1:0]  reg_d;
  logic [NREG-1:0][DATA_W-1:0]  reg_q;

  tac_rst_sync #(.STAGES(RST_STAGE)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  tac_decode #(.OP_W(OP_W)) u_decode (
    .op_i  (op_code),
    .ctl_o (ctl)
  );

  tac_alu #(.W(DATA_W)) u_alu (
    .sel_i (ctl.a_src),
    .acc_i (acc_q),
    .gpr_i (gpr_q),
    .bus_i (data_in),
    .y_o   (acc_next)
  );

  always_comb begin
    gpr_next = ctl.r_from_bus ? data_in : acc_q;
    out_next = ctl.o_from_acc ? acc_q : gpr_q;
  end

  assign reg_en = {ctl.o_en, ctl.r_en, ctl.a_en};
  assign reg_d  = {out_next, gpr_next, acc_next};

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    tac_reg #(.W(DATA_W)) u_reg (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .en_i  (reg_en[g]),
      .d_i   (reg_d[g]),
      .q_o   (reg_q[g])
    );
  end

  assign acc_q = reg_q[0];
  assign gpr_q = reg_q[1];
  assign out_q = reg_q[2];

endmodule

// File: rtl/tac_checker.sv
module tac_checker #(
  parameter int W    = 8,
  parameter int OP_W = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic [OP_W-1:0] op_i,
  input logic [W-1:0]    din_i,
  input logic [W-1:0]    acc_i,
  input logic [W-1:0]    gpr_i,
  input logic [W-1:0]    out_i
);

  logic seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen <= 1'b0;
    end else begin
      seen <= 1'b1;
    end
  end

  AST_LOAD_ACC: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && ($past(op_i) == 4'd1 || $past(op_i) == 4'd6)) |-> acc_i == $past(din_i)); // R1
  AST_GPR_FROM_ACC: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $past(op_i) == 4'd2) |-> gpr_i == $past(acc_i)); // R2
  AST_GPR_FROM_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $past(op_i) == 4'd5) |-> gpr_i == $past(din_i)); // R2
  AST_OUT_FROM_GPR: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $past(op_i) == 4'd3) |-> out_i == $past(gpr_i)); // R3
  AST_OUT_FROM_ACC: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $past(op_i) == 4'd4) |-> out_i == $past(acc_i)); // R3
  AST_ADD_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $past(op_i) == 4'd7) |-> acc_i == W'($past(acc_i) + $past(gpr_i))); // R4
  AST_IOR: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $past(op_i) == 4'd8) |-> acc_i == ($past(acc_i) | $past(gpr_i))); // R5
  AST_IAND: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $past(op_i) == 4'd9) |-> acc_i == ($past(acc_i) & $past(gpr_i))); // R5
  AST_INVERT: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $past(op_i) == 4'd10) |-> acc_i == ~$past(acc_i)); // R6
  AST_GPR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $past(op_i) != 4'd2 && $past(op_i) != 4'd5) |-> $stable(gpr_i)); // R7
  AST_ACC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $past(op_i) >= 4'd2 && $past(op_i) <= 4'd5) |-> $stable(acc_i)); // R8
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $past(op_i) != 4'd3 && $past(op_i) != 4'd4) |-> $stable(out_i)); // R9
  AST_IDLE_CODES: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && ($past(op_i) == 4'd0 || $past(op_i) >= 4'd11))
      |-> ($stable(acc_i) && $stable(gpr_i) && $stable(out_i))); // R10

  always_comb begin
    if (!rst_n) begin
      AST_RESET_ZERO: assert (acc_i == '0 && gpr_i == '0 && out_i == '0); // R11
    end
  end

endmodule

bind tiny_acc_core tac_checker #(.W(DATA_W), .OP_W(OP_W)) u_chk (
  .clk   (clk),
  .rst_n (rst_sync_n),
  .op_i  (op_code),
  .din_i (data_in),
  .acc_i (acc_q),
  .gpr_i (gpr_q),
  .out_i (out_q)
);

// File: tb/tiny_acc_core_tb.sv
`timescale 1ns/1ps
module tiny_acc_core_tb;

  localparam int W = 8;

  logic         clk;
  logic         rst_n;
  logic [3:0]   op_code;
  logic [W-1:0] data_in;
  logic [W-1:0] acc_q;
  logic [W-1:0] gpr_q;
  logic [W-1:0] out_q;

  logic [W-1:0] m_acc;
  logic [W-1:0] m_gpr;
  logic [W-1:0] m_out;

  int  n_vec;
  int  n_bad;
  bit  done;

  tiny_acc_core u_dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .op_code (op_code),
    .data_in (data_in),
    .acc_q   (acc_q),
    .gpr_q   (gpr_q),
    .out_q   (out_q)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic bit is_idle(input logic [3:0] op);
    return (op == 4'd0) || (op >= 4'd11);
  endfunction

  function automatic string tag_acc(input logic [3:0] op);
    if (op == 4'd1 || op == 4'd6) return "R1";
    if (op == 4'd7) return "R4";
    if (op == 4'd8 || op == 4'd9) return "R5";
    if (op == 4'd10) return "R6";
    if (is_idle(op)) return "R10";
    return "R8";
  endfunction

  function automatic string tag_gpr(input logic [3:0] op);
    if (op == 4'd2 || op == 4'd5) return "R2";
    if (is_idle(op)) return "R10";
    return "R7";
  endfunction

  function automatic string tag_out(input logic [3:0] op);
    if (op == 4'd3 || op == 4'd4) return "R3";
    if (is_idle(op)) return "R10";
    return "R9";
  endfunction

  function automatic logic [W-1:0] next_acc(input logic [3:0] op, input logic [W-1:0] a,
                                            input logic [W-1:0] r, input logic [W-1:0] d);
    case (op)
      4'd1, 4'd6: return d;
      4'd7:       return W'(a + r);
      4'd8:       return a | r;
      4'd9:       return a & r;
      4'd10:      return ~a;
      default:    return a;
    endcase
  endfunction

  function automatic logic [W-1:0] next_gpr(input logic [3:0] op, input logic [W-1:0] a,
                                            input logic [W-1:0] r, input logic [W-1:0] d);
    if (op == 4'd2) return a;
    if (op == 4'd5) return d;
    return r;
  endfunction

  function automatic logic [W-1:0] next_out(input logic [3:0] op, input logic [W-1:0] a,
                                            input logic [W-1:0] r, input logic [W-1:0] o);
    if (op == 4'd3) return r;
    if (op == 4'd4) return a;
    return o;
  endfunction

  task automatic compare(input string ta, input string tr, input string to);
    n_vec++;
    if (acc_q !== m_acc || gpr_q !== m_gpr || out_q !== m_out) n_bad++;
    if (acc_q !== m_acc) $display("FAIL %s acc: got %h expected %h", ta, acc_q, m_acc);
    if (gpr_q !== m_gpr) $display("FAIL %s gpr: got %h expected %h", tr, gpr_q, m_gpr);
    if (out_q !== m_out) $display("FAIL %s out: got %h expected %h", to, out_q, m_out);
  endtask

  // called at a falling edge; returns at the next falling edge after the update
  task automatic apply(input logic [3:0] op, input logic [W-1:0] d);
    logic [W-1:0] na, nr, no;
    op_code = op;
    data_in = d;
    na = next_acc(op, m_acc, m_gpr, d);
    nr = next_gpr(op, m_acc, m_gpr, d);
    no = next_out(op, m_acc, m_gpr, m_out);
    m_acc = na;
    m_gpr = nr;
    m_out = no;
    @(negedge clk);
    compare(tag_acc(op), tag_gpr(op), tag_out(op));
  endtask

  initial begin
    n_vec   = 0;
    n_bad   = 0;
    done    = 1'b0;
    rst_n   = 1'b0;
    op_code = 4'd1;
    data_in = 8'hFF;
    m_acc   = '0;
    m_gpr   = '0;
    m_out   = '0;

    // R11: held in reset with a load pending
    repeat (3) @(negedge clk);
    compare("R11", "R11", "R11");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R11", "R11", "R11");
    @(negedge clk);
    compare("R11", "R11", "R11");

    // R1 first executed code after release, then R2/R4 add with wrap
    apply(4'd1, 8'hFF);
    apply(4'd5, 8'h01);
    apply(4'd7, 8'h33);          // R4: FF + 01 wraps to 00
    apply(4'd6, 8'hA5);          // R1 alternate load code
    apply(4'd2, 8'h00);          // R2: gpr <= A5
    apply(4'd10, 8'hC3);         // R6: acc <= 5A
    apply(4'd8, 8'h00);          // R5: 5A | A5 = FF
    apply(4'd10, 8'h00);         // R6: 00
    apply(4'd6, 8'h5A);
    apply(4'd9, 8'hFF);          // R5: 5A & A5 = 00
    apply(4'd3, 8'h77);          // R3: out <= A5
    apply(4'd4, 8'h77);          // R3: out <= 00
    apply(4'd1, 8'h80);
    apply(4'd5, 8'h80);
    apply(4'd7, 8'h11);          // R4: 80 + 80 wraps to 00
    // R10: every idle code with a bus value unlike any register
    apply(4'd0,  8'h3C);
    apply(4'd11, 8'h3C);
    apply(4'd12, 8'h3C);
    apply(4'd13, 8'h3C);
    apply(4'd14, 8'h3C);
    apply(4'd15, 8'h3C);

    // random stream covering R1..R10
    void'($urandom(32'd20240607));
    for (int i = 0; i < 3000; i++) begin
      apply(4'($urandom % 16), W'($urandom));
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule